// File: doc/BRIEF.md
# Line-Synchronized Pixel/Line Counter with Shadowed Configuration Gate

This block tracks position inside a video field for a timing generator. A pixel counter advances once per master clock and is realigned to the horizontal drive input a fixed number of clock edges after that input falls. A line counter advances at each realignment and returns to zero at the line that starts a new field, recognised by the vertical drive falling one clock ahead of the horizontal drive.

Configuration reaches the block as plain register write strobes from an already decoded serial port. Timing words and the output-enable bit are written into a shadow copy. The copy moves to the active set only when a horizontal or vertical drive falling edge is seen while the hold-off bit is clear, so a whole group of settings changes at one boundary. A core-run bit, written directly and low at reset, keeps both counters at zero and all outputs at their inactive levels until software writes it to 1.

Top module: `line_sync_gate`

## Requirements
- R1: While `rst_n` is low, `pix_cnt`, `line_cnt`, `cfg_active` and `out_en` are all 0, and every register is cleared, so the core-run bit starts at 0.
- R2: While the core runs, `pix_cnt` rises by one on each clock edge. It stops at 4095 when no realignment happens.
- R3: Edge 1 is the first rising edge at which `hd_in` is sampled low after being high. `pix_cnt` becomes 0 on edge 6 and is 1 after edge 7.
- R4: Each pixel realignment that does not start a field raises `line_cnt` by one, and `line_cnt` stops at 4095.
- R5: A realignment whose `hd_in` fall comes one clock or less after a `vd_in` fall sets `line_cnt` to 0.
- R6: Register map, with data in bit 0 for the control registers: address 0 is core-run, address 1 is hold-off, address 2 is the shadow output-enable, and address 3+k is the shadow of timing word k. A write to the shadow leaves `cfg_active` and `out_en` unchanged until a transfer.
- R7: A transfer copies every shadow word and the output-enable bit to the active set on edge 2, counted as in R3, after an `hd_in` or `vd_in` fall, provided hold-off is 0 and the core runs.
- R8: While hold-off is 1, no transfer takes place. After hold-off is cleared, data written earlier is applied at the next drive falling edge.
- R9: `out_en` follows the shadow output-enable bit only through a transfer.
- R10: While core-run is 0, both counters, `out_en` and `cfg_active` are held at 0 from the next edge onward and transfers are suppressed. Shadow contents are kept. Writing 1 restarts counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_in | input | 1 | Horizontal drive, falling edge marks a line |
| vd_in | input | 1 | Vertical drive, falling edge marks a field |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | CFG_W (12) | Register write data |
| pix_cnt | output | CNT_W (12) | Pixel position within the line |
| line_cnt | output | CNT_W (12) | Line position within the field |
| cfg_active | output | NUM_CFG*CFG_W (48) | Active timing words, word k at bits k*CFG_W upward |
| out_en | output | 1 | Active output-enable |

## Verification
A corrupted realignment delay shows up as `pix_cnt` reaching 0 one or more cycles off edge 6, and this is visible within seven clocks of an `hd_in` fall. A wrong field flag shows up as `line_cnt` stepping where it should return to 0, at the first line of the next field. A faulty transfer gate shows up as a change of `cfg_active` or `out_en` at an edge where hold-off was set or no drive fell, or as a change that is missing two clocks after a fall. A core-run path that is not honoured leaves the counters moving one clock after the bit is written to 0.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  localparam int ADDR_CORE = 0;
  localparam int ADDR_HOLD = 1;
  localparam int ADDR_OE   = 2;
  localparam int ADDR_CFG0 = 3;

  typedef struct packed {
    logic vd_fall;
    logic hd_fall;
  } sync_ev_t;
endpackage

// File: rtl/lsg_fall_det.sv
module lsg_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic fall
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = sig_in;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign fall = s2_q & ~s1_q;
endmodule

// File: rtl/lsg_counters.sv
module lsg_counters #(
  parameter int CNT_W     = 12,
  parameter int SYNC_EDGE = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hd_fall,
  input  logic             vd_fall,
  output logic [CNT_W-1:0] pix_cnt,
  output logic [CNT_W-1:0] line_cnt
);
  localparam int DW = $clog2(SYNC_EDGE);
  localparam logic [DW-1:0]    DLY_LOAD = DW'(2);
  localparam logic [DW-1:0]    DLY_LAST = DW'(SYNC_EDGE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [DW-1:0]    dly_q, dly_d;
  logic             field_q, field_d;
  logic             vdf_q, vdf_d;
  logic [CNT_W-1:0] pix_q, pix_d;
  logic [CNT_W-1:0] line_q, line_d;
  logic             sync_now;

  always_comb begin
    sync_now = (dly_q == DLY_LAST);
    vdf_d    = vd_fall;
    field_d  = field_q;
    dly_d    = dly_q;
    if (hd_fall) begin
      dly_d   = DLY_LOAD;
      field_d = vd_fall | vdf_q;
    end else if (sync_now) begin
      dly_d = '0;
    end else if (dly_q != '0) begin
      dly_d = dly_q + DW'(1);
    end

    if (sync_now) pix_d = '0;
    else if (pix_q == CNT_MAX) pix_d = pix_q;
    else pix_d = pix_q + CNT_W'(1);

    line_d = line_q;
    if (sync_now) begin
      if (field_q) line_d = '0;
      else if (line_q != CNT_MAX) line_d = line_q + CNT_W'(1);
    end

    if (!run) begin
      dly_d   = '0;
      field_d = 1'b0;
      vdf_d   = 1'b0;
      pix_d   = '0;
      line_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q   <= '0;
      field_q <= 1'b0;
      vdf_q   <= 1'b0;
      pix_q   <= '0;
      line_q  <= '0;
    end else begin
      dly_q   <= dly_d;
      field_q <= field_d;
      vdf_q   <= vdf_d;
      pix_q   <= pix_d;
      line_q  <= line_d;
    end
  end

  assign pix_cnt  = pix_q;
  assign line_cnt = line_q;
endmodule

// File: rtl/lsg_shadow_regs.sv
module lsg_shadow_regs
  import lsg_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int CFG_W   = 12,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CFG_W-1:0]         wr_data,
  input  sync_ev_t                 ev,
  output logic                     core_run,
  output logic                     hold,
  output logic                     out_en,
  output logic [NUM_CFG*CFG_W-1:0] cfg_active
);
  logic core_q, core_d;
  logic hold_q, hold_d;
  logic oe_sh_q, oe_sh_d;
  logic oe_act_q, oe_act_d;
  logic xfer;

  assign xfer = core_q & ~hold_q & (ev.hd_fall | ev.vd_fall);

  always_comb begin
    core_d   = core_q;
    hold_d   = hold_q;
    oe_sh_d  = oe_sh_q;
    oe_act_d = oe_act_q;
    if (wr_en && wr_addr == ADDR_W'(ADDR_CORE)) core_d  = wr_data[0];
    if (wr_en && wr_addr == ADDR_W'(ADDR_HOLD)) hold_d  = wr_data[0];
    if (wr_en && wr_addr == ADDR_W'(ADDR_OE))   oe_sh_d = wr_data[0];
    if (!core_q) oe_act_d = 1'b0;
    else if (xfer) oe_act_d = oe_sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q   <= 1'b0;
      hold_q   <= 1'b0;
      oe_sh_q  <= 1'b0;
      oe_act_q <= 1'b0;
    end else begin
      core_q   <= core_d;
      hold_q   <= hold_d;
      oe_sh_q  <= oe_sh_d;
      oe_act_q <= oe_act_d;
    end
  end

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_word
    logic [CFG_W-1:0] sh_q, sh_d, act_q, act_d;
    logic             sel;

    assign sel = wr_en && (wr_addr == ADDR_W'(ADDR_CFG0 + k));

    always_comb begin
      sh_d  = sel ? wr_data : sh_q;
      act_d = act_q;
      if (!core_q) act_d = '0;
      else if (xfer) act_d = sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        sh_q  <= sh_d;
        act_q <= act_d;
      end
    end

    assign cfg_active[k*CFG_W +: CFG_W] = act_q;
  end

  assign core_run = core_q;
  assign hold     = hold_q;
  assign out_en   = oe_act_q;
endmodule

// File: rtl/line_sync_gate.sv
module line_sync_gate
  import lsg_pkg::*;
#(
  parameter int  CNT_W     = 12,
  parameter int  CFG_W     = 12,
  parameter int  NUM_CFG   = 4,
  parameter int  SYNC_EDGE = 6,
  localparam int ADDR_W    = $clog2(ADDR_CFG0 + NUM_CFG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hd_in,
  input  logic                     vd_in,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CFG_W-1:0]         wr_data,
  output logic [CNT_W-1:0]         pix_cnt,
  output logic [CNT_W-1:0]         line_cnt,
  output logic [NUM_CFG*CFG_W-1:0] cfg_active,
  output logic                     out_en
);
  logic [1:0] drv_in, drv_fall;
  sync_ev_t   ev;
  logic       core_run, hold_q;
  logic       hd_fall, vd_fall;

  assign drv_in = {vd_in, hd_in};

  for (genvar g = 0; g < 2; g++) begin : g_det
    lsg_fall_det i_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (drv_in[g]),
      .fall   (drv_fall[g])
    );
  end

  assign hd_fall    = drv_fall[0];
  assign vd_fall    = drv_fall[1];
  assign ev.hd_fall = hd_fall;
  assign ev.vd_fall = vd_fall;

  lsg_counters #(.CNT_W(CNT_W), .SYNC_EDGE(SYNC_EDGE)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (core_run),
    .hd_fall  (hd_fall),
    .vd_fall  (vd_fall),
    .pix_cnt  (pix_cnt),
    .line_cnt (line_cnt)
  );

  lsg_shadow_regs #(.NUM_CFG(NUM_CFG), .CFG_W(CFG_W), .ADDR_W(ADDR_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ev         (ev),
    .core_run   (core_run),
    .hold       (hold_q),
    .out_en     (out_en),
    .cfg_active (cfg_active)
  );
endmodule

// File: rtl/line_sync_gate_chk.sv
module line_sync_gate_chk #(
  parameter int CNT_W   = 12,
  parameter int CFG_TOT = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_run,
  input logic               hold,
  input logic               hd_fall,
  input logic               vd_fall,
  input logic [CNT_W-1:0]   pix_cnt,
  input logic [CNT_W-1:0]   line_cnt,
  input logic [CFG_TOT-1:0] cfg_active,
  input logic               out_en
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  p_pix_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && $past(core_run) && pix_cnt != '0) |->
      (pix_cnt == (($past(pix_cnt) == MAXV) ? MAXV : $past(pix_cnt) + CNT_W'(1))));

  p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && $past(core_run) && line_cnt != $past(line_cnt)) |->
      (pix_cnt == '0 && (line_cnt == '0 || line_cnt == $past(line_cnt) + CNT_W'(1))));

  p_xfer_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active != $past(cfg_active) || out_en != $past(out_en)) |->
      (!$past(core_run) || (($past(hd_fall) || $past(vd_fall)) && !$past(hold))));

  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(core_run) && $past(hold)) |-> ($stable(cfg_active) && $stable(out_en)));

  p_core_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_run && !$past(core_run)) |->
      (pix_cnt == '0 && line_cnt == '0 && !out_en && cfg_active == '0));
endmodule

bind line_sync_gate line_sync_gate_chk #(.CNT_W(CNT_W), .CFG_TOT(NUM_CFG*CFG_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_run   (core_run),
  .hold       (hold_q),
  .hd_fall    (hd_fall),
  .vd_fall    (vd_fall),
  .pix_cnt    (pix_cnt),
  .line_cnt   (line_cnt),
  .cfg_active (cfg_active),
  .out_en     (out_en)
);

// File: tb/test_line_sync_gate.sv
module test_line_sync_gate;
  localparam int CNT_W = 12;
  localparam int CFG_W = 12;
  localparam int NCFG  = 4;
  localparam int AW    = 3;
  localparam int NVEC  = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hd_in = 1'b1;
  logic              vd_in = 1'b1;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [CFG_W-1:0]  wr_data = '0;
  logic [CNT_W-1:0]  pix_cnt, line_cnt;
  logic [NCFG*CFG_W-1:0] cfg_active;
  logic              out_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  line_sync_gate i_line_sync_gate (
    .clk(clk), .rst_n(rst_n), .hd_in(hd_in), .vd_in(vd_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .cfg_active(cfg_active), .out_en(out_en)
  );

  // {hold, addr, data, edge kind (0 none, 1 hd, 2 vd), exp word0, exp word1, exp oe}
  typedef struct packed {
    logic        hold;
    logic [2:0]  addr;
    logic [11:0] data;
    logic [1:0]  kind;
    logic [11:0] exp0;
    logic [11:0] exp1;
    logic        exp_oe;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 3'd3, 12'h123, 2'd0, 12'h000, 12'h000, 1'b0},  // R6
    '{1'b0, 3'd3, 12'h123, 2'd1, 12'h123, 12'h000, 1'b0},  // R7
    '{1'b1, 3'd3, 12'h456, 2'd1, 12'h123, 12'h000, 1'b0},  // R8
    '{1'b1, 3'd2, 12'h001, 2'd2, 12'h123, 12'h000, 1'b0},  // R8 R9
    '{1'b0, 3'd3, 12'h456, 2'd0, 12'h123, 12'h000, 1'b0},  // R8
    '{1'b0, 3'd4, 12'h0AA, 2'd2, 12'h456, 12'h0AA, 1'b1},  // R8 R9
    '{1'b0, 3'd2, 12'h000, 2'd0, 12'h456, 12'h0AA, 1'b1},  // R9
    '{1'b0, 3'd2, 12'h000, 2'd1, 12'h456, 12'h0AA, 1'b0},  // R9
    '{1'b0, 3'd6, 12'hFFF, 2'd1, 12'h456, 12'h0AA, 1'b0}   // R7
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CFG_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hd_pulse();
    hd_in = 1'b0;
    repeat (3) @(negedge clk);
    hd_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] p0, l0;
    repeat (3) @(negedge clk);
    chk("R1 reset pix", pix_cnt, 0);
    chk("R1 reset out", {cfg_active, out_en, line_cnt}, 0);
    rst_n = 1'b1;

    // R10: core held after reset, HD ignored
    @(negedge clk); hd_pulse();
    chk("R10 held pix", pix_cnt, 0);
    chk("R10 held line", line_cnt, 0);

    // R2: counting starts after core-run write
    wr(3'd0, 12'd1);
    repeat (5) @(negedge clk);
    chk("R2 count", pix_cnt, 5);

    foreach (VEC[i]) begin
      wr(3'd1, {11'd0, VEC[i].hold});
      wr(VEC[i].addr, VEC[i].data);
      if (VEC[i].kind == 2'd1) hd_pulse();
      else if (VEC[i].kind == 2'd2) begin
        vd_in = 1'b0; repeat (3) @(negedge clk); vd_in = 1'b1; repeat (6) @(negedge clk);
      end else repeat (4) @(negedge clk);
      chk($sformatf("R6-9 vec%0d word0", i), cfg_active[11:0], VEC[i].exp0);
      chk($sformatf("R6-9 vec%0d word1", i), cfg_active[23:12], VEC[i].exp1);
      chk($sformatf("R9 vec%0d oe", i), out_en, VEC[i].exp_oe);
    end

    // R3: exact realignment edge
    p0 = pix_cnt; l0 = line_cnt;
    hd_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 before edge 6", pix_cnt, p0 + 5);
    @(negedge clk);
    chk("R3 at edge 6", pix_cnt, 0);
    chk("R4 line step", line_cnt, l0 + 1);
    @(negedge clk);
    chk("R3 after edge 7", pix_cnt, 1);
    hd_in = 1'b1;
    repeat (4) @(negedge clk);

    // R5: field start
    vd_in = 1'b0;
    @(negedge clk);
    hd_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 line zero", line_cnt, 0);
    chk("R5 pix zero", pix_cnt, 0);
    vd_in = 1'b1; hd_in = 1'b1;
    repeat (4) @(negedge clk);
    hd_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 next line", line_cnt, 1);
    hd_in = 1'b1;

    // R2 saturation
    repeat (4200) @(negedge clk);
    chk("R2 pix saturate", pix_cnt, 4095);
    @(negedge clk);
    chk("R2 pix stays", pix_cnt, 4095);

    // R4 saturation
    for (int n = 0; n < 4100; n++) begin
      hd_in = 1'b0; repeat (4) @(negedge clk);
      hd_in = 1'b1; repeat (4) @(negedge clk);
    end
    chk("R4 line saturate", line_cnt, 4095);

    // R10: stop core
    wr(3'd0, 12'd0);
    @(negedge clk);
    chk("R10 stop counters", {pix_cnt, line_cnt}, 0);
    chk("R10 stop outputs", {cfg_active, out_en}, 0);
    wr(3'd2, 12'd1);
    hd_pulse();
    chk("R10 no transfer", {cfg_active, out_en}, 0);
    wr(3'd0, 12'd1);
    hd_pulse();
    chk("R10 shadow kept", cfg_active[11:0], 12'h456);
    chk("R10 oe restored", out_en, 1);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {cfg_active, out_en, pix_cnt, line_cnt}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 core off after reset", pix_cnt, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule